// File: doc/BRIEF.md
# Block-Write Bus Cycle Sequencer

This block is the controller-side state machine that runs one block-write cycle to video memory over a shared address/data bus. A request carries a bus address, a write-enable mask of four bits per memory device and a plane-mask value. Once a request is accepted, the sequencer drives the row strobe, column strobe, write enable, transfer/output enable and special-function strobe (all strobes active low except the special-function line) through a fixed order of states. Each state lasts one clock.

While the address is on the bus, the low nibble of the bus carries a status code. This code tells external logic that a block write is in progress. In the data phase the bus carries the nibble-enable mask instead of pixel data. When the plane mask is all zeros, one extra stretch state is added between the row strobe falling and the column being presented.

The multiplexed row/column address and all strobes come straight from registers, so they are stable before each strobe edge. A ready output is high only while the block is idle. A one-cycle done pulse follows the precharge state.

Top module: `bwr_sequencer`

## Requirements
- R1: While reset is asserted and in idle, rasN, casN, weN and trqeN are 1, sf is 0, busLad and rowColAddr are 0, done is 0 and reqReady is 1.
- R2: reqReady is 1 only in idle. A request is taken only when reqValid and reqReady are both 1 at a clock edge. reqValid while busy has no effect on the running cycle, and no further cycle starts from it.
- R3: From the first clock after acceptance until the column is presented, busLad equals {reqAddr, 4'b1110}: the address in bits BUS_W-1..4 and the status code 1110 in bits 3..0.
- R4: The row state (all strobes high) lasts one clock before rasN falls. At the clock where rasN goes low, casN, weN and trqeN are 1 and sf is 0. Throughout both states rowColAddr holds the row, reqAddr[2*RC_W-1:RC_W].
- R5: sf rises at least one clock before casN falls. From that clock until idle, rowColAddr holds the column, reqAddr[RC_W-1:0].
- R6: In the column and CAS states, busLad equals the mask zero-extended to BUS_W bits. Bit 4*d+k enables nibble k of device d.
- R7: If reqPlaneMask is 0 at acceptance, a stretch state is inserted (rasN low, sf 1, address still on busLad, column on rowColAddr), and rasN stays low 4 clocks. Otherwise the stretch state is skipped and rasN stays low 3 clocks.
- R8: In the CAS state, casN and weN are 0 for exactly one clock while rasN is 0.
- R9: After CAS comes one precharge clock with rasN, casN, weN at 1, sf 0 and busLad 0. This is followed by idle with done at 1 for exactly one clock.
- R10: trqeN is 1 at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Request present |
| reqAddr | input | ADDR_W | Bus address; low 2*RC_W bits give column and row |
| reqMask | input | MASK_W | Nibble-enable mask, 4 bits per device |
| reqPlaneMask | input | PM_W | Plane mask; all zeros selects the stretch state |
| reqReady | output | 1 | Idle and able to accept |
| busLad | output | BUS_W | Multiplexed address/status/mask bus |
| rowColAddr | output | RC_W | Multiplexed row/column address to memory |
| rasN | output | 1 | Row strobe, active low |
| casN | output | 1 | Column strobe, active low |
| weN | output | 1 | Write enable, active low |
| trqeN | output | 1 | Transfer/output enable, active low |
| sf | output | 1 | Special-function strobe, active high |
| done | output | 1 | One-clock end-of-cycle pulse |

## Verification
All outputs are registered, so the row state appears in the clock directly after the accepting edge. Each later state follows one edge after the one before. done arrives after the 6th edge with the stretch state and after the 5th edge without it. The bench drives inputs on falling edges and samples every output on the falling edge of each phase. It compares them against a per-phase expectation that depends on whether a stretch was selected. While a cycle is running, it holds a conflicting request valid to show that the request is ignored.

// File: rtl/bwr_pkg.sv
package bwr_pkg;

  localparam logic [3:0] STATUS_BLOCK_WRITE = 4'b1110;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ROW,
    ST_RAS,
    ST_STRETCH,
    ST_COL,
    ST_CAS,
    ST_PRE
  } bwrState_e;

  typedef enum logic [1:0] {
    LAD_ZERO,
    LAD_ADDR,
    LAD_MASK
  } ladSel_e;

  typedef enum logic [1:0] {
    RCA_ZERO,
    RCA_ROW,
    RCA_COL
  } rcaSel_e;

  typedef struct packed {
    logic    load;
    logic    rasN;
    logic    casN;
    logic    weN;
    logic    trqeN;
    logic    sf;
    ladSel_e ladSel;
    rcaSel_e rcaSel;
    logic    done;
  } bwrStrobes_t;

endpackage

// File: rtl/bwr_ctrl.sv
module bwr_ctrl
  import bwr_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        planeMaskZero,
  output logic        reqReady,
  output bwrStrobes_t strobes
);

  bwrState_e state;
  bwrState_e nextState;
  logic      stretchQ;
  logic      accept;

  assign reqReady = (state == ST_IDLE);
  assign accept   = reqValid && reqReady;

  always_comb begin
    nextState = state;
    case (state)
      ST_IDLE:    if (accept) nextState = ST_ROW;
      ST_ROW:     nextState = ST_RAS;
      ST_RAS:     nextState = stretchQ ? ST_STRETCH : ST_COL;
      ST_STRETCH: nextState = ST_COL;
      ST_COL:     nextState = ST_CAS;
      ST_CAS:     nextState = ST_PRE;
      ST_PRE:     nextState = ST_IDLE;
      default:    nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      stretchQ <= 1'b0;
    end else begin
      state <= nextState;
      if (accept) stretchQ <= planeMaskZero;
    end
  end

  // Levels decoded from the next state; the datapath registers them.
  always_comb begin
    strobes        = '0;
    strobes.load   = accept;
    strobes.rasN   = 1'b1;
    strobes.casN   = 1'b1;
    strobes.weN    = 1'b1;
    strobes.trqeN  = 1'b1;
    strobes.sf     = 1'b0;
    strobes.ladSel = LAD_ZERO;
    strobes.rcaSel = RCA_ZERO;
    strobes.done   = (state == ST_PRE);
    case (nextState)
      ST_ROW: begin
        strobes.ladSel = LAD_ADDR;
        strobes.rcaSel = RCA_ROW;
      end
      ST_RAS: begin
        strobes.rasN   = 1'b0;
        strobes.ladSel = LAD_ADDR;
        strobes.rcaSel = RCA_ROW;
      end
      ST_STRETCH: begin
        strobes.rasN   = 1'b0;
        strobes.sf     = 1'b1;
        strobes.ladSel = LAD_ADDR;
        strobes.rcaSel = RCA_COL;
      end
      ST_COL: begin
        strobes.rasN   = 1'b0;
        strobes.sf     = 1'b1;
        strobes.ladSel = LAD_MASK;
        strobes.rcaSel = RCA_COL;
      end
      ST_CAS: begin
        strobes.rasN   = 1'b0;
        strobes.casN   = 1'b0;
        strobes.weN    = 1'b0;
        strobes.sf     = 1'b1;
        strobes.ladSel = LAD_MASK;
        strobes.rcaSel = RCA_COL;
      end
      ST_PRE: begin
        strobes.rcaSel = RCA_COL;
      end
      default: begin
      end
    endcase
  end

endmodule

// File: rtl/bwr_datapath.sv
module bwr_datapath
  import bwr_pkg::*;
#(
  parameter int ADDR_W = 28,
  parameter int MASK_W = 32,
  parameter int RC_W   = 10,
  localparam int BUS_W = ADDR_W + 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  bwrStrobes_t       strobes,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [MASK_W-1:0] reqMask,
  output logic [BUS_W-1:0]  busLad,
  output logic [RC_W-1:0]   rowColAddr,
  output logic              rasN,
  output logic              casN,
  output logic              weN,
  output logic              trqeN,
  output logic              sf,
  output logic              done
);

  logic [ADDR_W-1:0] addrQ;
  logic [MASK_W-1:0] maskQ;
  logic [ADDR_W-1:0] addrSrc;
  logic [MASK_W-1:0] maskSrc;
  logic [BUS_W-1:0]  ladNext;
  logic [RC_W-1:0]   rcaNext;

  // On the accepting edge the captured copy is not yet loaded.
  assign addrSrc = strobes.load ? reqAddr : addrQ;
  assign maskSrc = strobes.load ? reqMask : maskQ;

  always_comb begin
    case (strobes.ladSel)
      LAD_ADDR: ladNext = {addrSrc, STATUS_BLOCK_WRITE};
      LAD_MASK: ladNext = BUS_W'(maskSrc);
      default:  ladNext = '0;
    endcase
    case (strobes.rcaSel)
      RCA_ROW: rcaNext = addrSrc[2*RC_W-1:RC_W];
      RCA_COL: rcaNext = addrSrc[RC_W-1:0];
      default: rcaNext = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ      <= '0;
      maskQ      <= '0;
      busLad     <= '0;
      rowColAddr <= '0;
      rasN       <= 1'b1;
      casN       <= 1'b1;
      weN        <= 1'b1;
      trqeN      <= 1'b1;
      sf         <= 1'b0;
      done       <= 1'b0;
    end else begin
      if (strobes.load) begin
        addrQ <= reqAddr;
        maskQ <= reqMask;
      end
      busLad     <= ladNext;
      rowColAddr <= rcaNext;
      rasN       <= strobes.rasN;
      casN       <= strobes.casN;
      weN        <= strobes.weN;
      trqeN      <= strobes.trqeN;
      sf         <= strobes.sf;
      done       <= strobes.done;
    end
  end

endmodule

// File: rtl/bwr_sequencer.sv
module bwr_sequencer
  import bwr_pkg::*;
#(
  parameter int ADDR_W = 28,
  parameter int NDEV   = 8,
  parameter int RC_W   = 10,
  parameter int PM_W   = 16,
  localparam int MASK_W = 4 * NDEV,
  localparam int BUS_W  = ADDR_W + 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [MASK_W-1:0] reqMask,
  input  logic [PM_W-1:0]   reqPlaneMask,
  output logic              reqReady,
  output logic [BUS_W-1:0]  busLad,
  output logic [RC_W-1:0]   rowColAddr,
  output logic              rasN,
  output logic              casN,
  output logic              weN,
  output logic              trqeN,
  output logic              sf,
  output logic              done
);

  bwrStrobes_t strobes;

  bwr_ctrl u_ctrl (
    .clk           (clk),
    .rstN          (rstN),
    .reqValid      (reqValid),
    .planeMaskZero (reqPlaneMask == '0),
    .reqReady      (reqReady),
    .strobes       (strobes)
  );

  bwr_datapath #(
    .ADDR_W (ADDR_W),
    .MASK_W (MASK_W),
    .RC_W   (RC_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .reqAddr    (reqAddr),
    .reqMask    (reqMask),
    .busLad     (busLad),
    .rowColAddr (rowColAddr),
    .rasN       (rasN),
    .casN       (casN),
    .weN        (weN),
    .trqeN      (trqeN),
    .sf         (sf),
    .done       (done)
  );

endmodule

// File: rtl/bwr_sequencer_checker.sv
module bwr_sequencer_checker (
  input logic       clk,
  input logic       rstN,
  input logic       reqValid,
  input logic       reqReady,
  input logic [3:0] ladLow,
  input logic       rasN,
  input logic       casN,
  input logic       weN,
  input logic       trqeN,
  input logic       sf,
  input logic       done
);

  logic [2:0] rasLowCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rasLowCnt <= '0;
    else if (rasN) rasLowCnt <= '0;
    else if (rasLowCnt != 3'd7) rasLowCnt <= rasLowCnt + 3'd1;
  end

  assert_busy_only_after_request_R2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(reqReady) |-> $past(reqValid));

  assert_status_code_R3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rasN) |-> ladLow == 4'b1110);

  assert_ras_fall_levels_R4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rasN) |-> (casN && weN && trqeN && !sf));

  assert_sf_before_cas_R5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(casN) |-> (sf && $past(sf)));

  assert_ras_low_length_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rasN) |-> (rasLowCnt == 3'd3 || rasLowCnt == 3'd4));

  assert_write_in_cas_R8: assert property (@(posedge clk) disable iff (!rstN)
    !weN |-> (!casN && !rasN));

  assert_cas_one_clock_R8: assert property (@(posedge clk) disable iff (!rstN)
    !casN |=> casN);

  assert_done_strobes_high_R9: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (rasN && casN && $past(rasN) && $past(casN)));

  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_trqe_high_R10: assert property (@(posedge clk) disable iff (!rstN)
    trqeN);

endmodule

bind bwr_sequencer bwr_sequencer_checker u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .reqValid (reqValid),
  .reqReady (reqReady),
  .ladLow   (busLad[3:0]),
  .rasN     (rasN),
  .casN     (casN),
  .weN      (weN),
  .trqeN    (trqeN),
  .sf       (sf),
  .done     (done)
);

// File: tb/bwr_sequencer_bench.sv
`timescale 1ns/1ps
module bwr_sequencer_bench;

  localparam int ADDR_W = 28;
  localparam int NDEV   = 8;
  localparam int RC_W   = 10;
  localparam int PM_W   = 16;
  localparam int MASK_W = 4 * NDEV;
  localparam int BUS_W  = ADDR_W + 4;

  // phase codes used by the bench only
  localparam int P_IDLE = 0, P_ROW = 1, P_RAS = 2, P_STR = 3, P_COL = 4, P_CAS = 5, P_PRE = 6;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              reqValid = 1'b0;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic [MASK_W-1:0] reqMask = '0;
  logic [PM_W-1:0]   reqPlaneMask = '0;
  logic              reqReady;
  logic [BUS_W-1:0]  busLad;
  logic [RC_W-1:0]   rowColAddr;
  logic              rasN, casN, weN, trqeN, sf, done;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  bwr_sequencer u_bwr_sequencer (
    .clk (clk), .rstN (rstN), .reqValid (reqValid), .reqAddr (reqAddr),
    .reqMask (reqMask), .reqPlaneMask (reqPlaneMask), .reqReady (reqReady),
    .busLad (busLad), .rowColAddr (rowColAddr), .rasN (rasN), .casN (casN),
    .weN (weN), .trqeN (trqeN), .sf (sf), .done (done)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int phaseOf(input int i, input bit stretch);
    int seqS[7] = '{P_ROW, P_RAS, P_STR, P_COL, P_CAS, P_PRE, P_IDLE};
    int seqN[6] = '{P_ROW, P_RAS, P_COL, P_CAS, P_PRE, P_IDLE};
    return stretch ? seqS[i-1] : seqN[i-1];
  endfunction

  // {rasN, casN, weN, sf}
  function automatic logic [3:0] expStrobe(input int p);
    case (p)
      P_RAS:   return 4'b0110;
      P_STR:   return 4'b0111;
      P_COL:   return 4'b0111;
      P_CAS:   return 4'b0001;
      default: return 4'b1110;
    endcase
  endfunction

  function automatic logic [BUS_W-1:0] expLad(input int p, input logic [ADDR_W-1:0] a,
                                              input logic [MASK_W-1:0] m);
    if (p == P_ROW || p == P_RAS || p == P_STR) return {a, 4'b1110};
    if (p == P_COL || p == P_CAS) return BUS_W'(m);
    return '0;
  endfunction

  function automatic logic [RC_W-1:0] expRca(input int p, input logic [ADDR_W-1:0] a);
    if (p == P_ROW || p == P_RAS) return a[2*RC_W-1:RC_W];
    if (p == P_IDLE) return '0;
    return a[RC_W-1:0];
  endfunction

  function automatic string tagOf(input int p);
    case (p)
      P_ROW, P_RAS: return "R4 row/ras";
      P_STR:        return "R7 stretch";
      P_COL:        return "R5 column";
      P_CAS:        return "R8 cas";
      default:      return "R9 precharge/done";
    endcase
  endfunction

  task automatic runReq(input logic [ADDR_W-1:0] a, input logic [MASK_W-1:0] m,
                        input logic [PM_W-1:0] pm, input bit junk);
    bit stretch = (pm == '0);
    int n = stretch ? 7 : 6;
    @(negedge clk);
    chk("R2 ready before request", 64'(reqReady), 64'd1);
    reqValid = 1'b1; reqAddr = a; reqMask = m; reqPlaneMask = pm;
    @(posedge clk);
    for (int i = 1; i <= n; i++) begin
      int p;
      @(negedge clk);
      p = phaseOf(i, stretch);
      if (i == 1) begin
        if (junk) begin
          reqAddr = ~a; reqMask = ~m; reqPlaneMask = ~pm;
        end else begin
          reqValid = 1'b0;
        end
      end
      if (i == n - 1) reqValid = 1'b0;
      chk(tagOf(p), 64'({rasN, casN, weN, sf}), 64'(expStrobe(p)));
      chk((p == P_COL || p == P_CAS) ? "R6 mask on bus" :
          (p == P_IDLE || p == P_PRE) ? "R9 bus idle" : "R3 address+status",
          64'(busLad), 64'(expLad(p, a, m)));
      chk(p == P_ROW || p == P_RAS ? "R4 row addr" : "R5 col addr",
          64'(rowColAddr), 64'(expRca(p, a)));
      chk("R9 done", 64'(done), 64'(p == P_IDLE));
      chk("R2 ready", 64'(reqReady), 64'(p == P_IDLE));
      chk("R10 trqeN", 64'(trqeN), 64'd1);
    end
    @(negedge clk);
    chk("R9 done single", 64'(done), 64'd0);
    chk("R2 no extra cycle", 64'({reqReady, rasN}), 64'b11);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int seedDummy;
    seedDummy = $urandom(32'h5EED);
    // R1 during reset
    reqValid = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 strobes in reset", 64'({rasN, casN, weN, trqeN, sf}), 64'b11110);
    chk("R1 bus in reset", 64'({busLad, rowColAddr}), 64'd0);
    chk("R1 done/ready in reset", 64'({done, reqReady}), 64'b01);
    reqValid = 1'b0;
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 idle after reset", 64'({rasN, casN, weN, trqeN, sf, done}), 64'b111100);

    // directed corners
    runReq('1, '1, '0, 1'b0);                   // R7 stretch, all-ones mask
    runReq('0, '0, 16'h0001, 1'b0);             // R7 no stretch, zero mask
    runReq(28'h0ABCDEF, 32'h8000_0001, '0, 1'b1);   // R2 ignored request while busy
    runReq(28'h5A5A5A5, 32'h0F0F_F0F0, 16'h8000, 1'b1);

    // random mix
    for (int k = 0; k < 40; k++) begin
      logic [ADDR_W-1:0] a = ADDR_W'($urandom);
      logic [MASK_W-1:0] m = MASK_W'($urandom);
      logic [PM_W-1:0]   pm = ($urandom % 2) ? '0 : PM_W'($urandom);
      runReq(a, m, pm, bit'($urandom % 2));
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule